// File: doc/BRIEF.md
# Modem Control and Status Unit with Loopback

This block keeps the five-bit modem control word of a serial port and builds the eight-bit modem status byte that software reads. The control word drives four output pins. In loopback mode those pins are held inactive, and the control bits are fed back internally as the four status lines. Every cycle the block compares each status line with its value from the previous cycle. A change sets a sticky change flag and raises a modem-status event toward the interrupt arbiter. Reading the status byte clears the flags and the event.

Outside loopback the status lines read as zero in the default configuration. The parameter `EXT_LIVE` selects an alternative in which the external modem inputs drive the status lines instead. They pass through `SYNC_STAGES` synchronizing flops first, and their changes are detected in the same way.

Top module: `mdm_ctl_stat`

## Requirements
- R1: A control write stores data bits 4:0. Bit 0 is DTR, bit 1 RTS, bit 2 OUT1, bit 3 OUT2 and bit 4 loopback. `ctl_rdata_o` returns them in the same positions, with bits 7:5 reading 0. The register resets to 0.
- R2: With loopback off, the pins `pin_dtr_o`, `pin_rts_o`, `pin_out1_o` and `pin_out2_o` show DTR, RTS, OUT1 and OUT2 from the clock edge that performs the write.
- R3: With loopback on, all four control pins are driven to their inactive level 0.
- R4: With loopback on, the status lines in `sts_rdata_o` are CTS (bit 4) = RTS, DSR (bit 5) = DTR, RI (bit 6) = OUT1 and DCD (bit 7) = OUT2. They are valid from the write edge.
- R5: With loopback off and `EXT_LIVE`=0, status bits 7:4 read 0 whatever the external inputs do. No flag or event comes from those inputs.
- R6: Any change of CTS, DSR or DCD sets its flag: bit 0, bit 1 or bit 3 of the status byte. The flag appears one clock edge after the line changes.
- R7: The RI flag (status bit 2) is set only when RI goes from 1 to 0. A rise of RI does not set it.
- R8: Any change of any status line, a rise of RI included, sets `ms_event_o` one edge after the change.
- R9: A cycle with `sts_re_i` high returns the flags as they were before the read. At that edge the read clears all four flags and `ms_event_o`.
- R10: A line change detected at the same edge as a read is not lost. Its flag and the event are set after that edge.
- R11: Without a read and without a further line change, the flags and `ms_event_o` hold their values.
- R12: With `EXT_LIVE`=1 and loopback off, an external input change appears on its status bit `SYNC_STAGES` edges later. Its flag and event appear one edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 8 | Control write data |
| ctl_rdata_o | output | 8 | Control word readback |
| sts_re_i | input | 1 | Status read strobe (clears flags and event) |
| sts_rdata_o | output | 8 | Status byte: flags in 3:0, lines in 7:4 |
| ext_cts_i | input | 1 | External clear-to-send input |
| ext_dsr_i | input | 1 | External data-set-ready input |
| ext_ri_i | input | 1 | External ring input |
| ext_dcd_i | input | 1 | External carrier-detect input |
| pin_dtr_o | output | 1 | Data-terminal-ready pin |
| pin_rts_o | output | 1 | Request-to-send pin |
| pin_out1_o | output | 1 | General output 1 pin |
| pin_out2_o | output | 1 | General output 2 pin |
| ms_event_o | output | 1 | Modem-status event to the interrupt arbiter |

## Verification
The control readback, the pins and the loopback status lines change at the write edge itself. The bench checks them at the falling edge right after the write. At that same point it also confirms that the change flags and the event are still clear. It then checks the flags and the event at the next falling edge, one register later. Reads are checked twice: the returned byte is sampled before the clearing edge, and the cleared state is sampled after it. For the synchronized variant, the status bit is checked at the falling edges after each of the `SYNC_STAGES` flops, and the flag one edge after the last one.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

    // control word, packed so that bit positions match the write data
    typedef struct packed {
        logic loop;
        logic out2;
        logic out1;
        logic rts;
        logic dtr;
    } mctl_t;

    // four status lines (or their change flags), bit 0 .. bit 3
    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } mline_t;

    localparam int CTL_W  = $bits(mctl_t);
    localparam int LINE_W = $bits(mline_t);

endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    generate
        if (STAGES == 0) begin : g_pass
            assign sync_o = async_i;
        end else begin : g_chain
            logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

            always_comb begin
                chain_d[0] = async_i;
                for (int i = 1; i < STAGES; i++) begin
                    chain_d[i] = chain_q[i-1];
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= chain_d;
            end

            assign sync_o = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/mdm_delta.sv
module mdm_delta
    import mdm_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  mline_t lines_i,
    input  logic   rd_i,
    output mline_t flags_o,
    output logic   pend_o
);

    typedef struct packed {
        mline_t prev;
        mline_t flags;
        logic   pend;
    } dstate_t;

    dstate_t st_d, st_q;
    mline_t  chg, hit;

    always_comb begin
        chg     = lines_i ^ st_q.prev;
        hit     = chg;
        hit.ri  = st_q.prev.ri & ~lines_i.ri;
        st_d      = st_q;
        st_d.prev = lines_i;
        st_d.flags = (rd_i ? mline_t'('0) : st_q.flags) | hit;
        st_d.pend  = (rd_i ? 1'b0 : st_q.pend) | (|chg);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;
    assign pend_o  = st_q.pend;

    // R8
    event_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lines_i != st_q.prev) |=> st_q.pend);

    // R7
    ri_fall_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.prev.ri && !lines_i.ri) |=> st_q.flags.ri);

    // R9
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && lines_i == st_q.prev) |=> (st_q.flags == '0 && !st_q.pend));

    // R11
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_i && lines_i == st_q.prev) |=> ($stable(st_q.flags) && $stable(st_q.pend)));

endmodule

// File: rtl/mdm_ctl_stat.sv
module mdm_ctl_stat
    import mdm_pkg::*;
#(
    parameter bit EXT_LIVE    = 1'b0,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_we_i,
    input  logic [7:0] ctl_wdata_i,
    output logic [7:0] ctl_rdata_o,
    input  logic       sts_re_i,
    output logic [7:0] sts_rdata_o,
    input  logic       ext_cts_i,
    input  logic       ext_dsr_i,
    input  logic       ext_ri_i,
    input  logic       ext_dcd_i,
    output logic       pin_dtr_o,
    output logic       pin_rts_o,
    output logic       pin_out1_o,
    output logic       pin_out2_o,
    output logic       ms_event_o
);

    localparam int PAD_W = 8 - CTL_W;

    typedef struct packed {
        mctl_t ctl;
    } tstate_t;

    tstate_t st_d, st_q;
    mline_t  ext_raw, ext_s, lines, flags;
    logic    wdata_unused;

    assign wdata_unused = ^ctl_wdata_i[7:CTL_W];

    always_comb begin
        st_d = st_q;
        if (ctl_we_i) st_d.ctl = mctl_t'(ctl_wdata_i[CTL_W-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ext_raw = '{dcd: ext_dcd_i, ri: ext_ri_i, dsr: ext_dsr_i, cts: ext_cts_i};

    mdm_sync #(.WIDTH(LINE_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ext_raw),
        .sync_o  (ext_s)
    );

    always_comb begin
        if (st_q.ctl.loop) begin
            lines.cts = st_q.ctl.rts;
            lines.dsr = st_q.ctl.dtr;
            lines.ri  = st_q.ctl.out1;
            lines.dcd = st_q.ctl.out2;
        end else begin
            lines = EXT_LIVE ? ext_s : mline_t'('0);
        end
    end

    mdm_delta u_delta (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines_i (lines),
        .rd_i    (sts_re_i),
        .flags_o (flags),
        .pend_o  (ms_event_o)
    );

    assign ctl_rdata_o = {{PAD_W{1'b0}}, st_q.ctl};
    assign sts_rdata_o = {lines, flags};

    assign pin_dtr_o  = st_q.ctl.dtr  & ~st_q.ctl.loop;
    assign pin_rts_o  = st_q.ctl.rts  & ~st_q.ctl.loop;
    assign pin_out1_o = st_q.ctl.out1 & ~st_q.ctl.loop;
    assign pin_out2_o = st_q.ctl.out2 & ~st_q.ctl.loop;

    // R1
    ctl_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we_i |=> (ctl_rdata_o == {3'b000, $past(ctl_wdata_i[4:0])}));

    // R3
    loop_pins_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we_i && ctl_wdata_i[4])
        |=> ({pin_dtr_o, pin_rts_o, pin_out1_o, pin_out2_o} == 4'b0000));

    // R4
    loop_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we_i && ctl_wdata_i[4])
        |=> (sts_rdata_o[7:4] == {$past(ctl_wdata_i[3]), $past(ctl_wdata_i[2]),
                                  $past(ctl_wdata_i[0]), $past(ctl_wdata_i[1])}));

endmodule

// File: tb/sim_mdm_ctl_stat.sv
module sim_mdm_ctl_stat;

    localparam int CLK_PER = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_we = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic [7:0] ctl_rdata;
    logic       sts_re = 1'b0;
    logic [7:0] sts_rdata;
    logic [3:0] ext = '0;   // {dcd, ri, dsr, cts}
    logic       p_dtr, p_rts, p_out1, p_out2, ms_ev;

    logic [3:0] ext1 = '0;
    logic [7:0] ctl_rdata1, sts_rdata1;
    logic       p1_dtr, p1_rts, p1_out1, p1_out2, ms_ev1;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    mdm_ctl_stat u0 (
        .clk(clk), .rst_n(rst_n),
        .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wdata), .ctl_rdata_o(ctl_rdata),
        .sts_re_i(sts_re), .sts_rdata_o(sts_rdata),
        .ext_cts_i(ext[0]), .ext_dsr_i(ext[1]), .ext_ri_i(ext[2]), .ext_dcd_i(ext[3]),
        .pin_dtr_o(p_dtr), .pin_rts_o(p_rts), .pin_out1_o(p_out1), .pin_out2_o(p_out2),
        .ms_event_o(ms_ev)
    );

    mdm_ctl_stat #(.EXT_LIVE(1'b1), .SYNC_STAGES(2)) u1 (
        .clk(clk), .rst_n(rst_n),
        .ctl_we_i(1'b0), .ctl_wdata_i(8'h00), .ctl_rdata_o(ctl_rdata1),
        .sts_re_i(1'b0), .sts_rdata_o(sts_rdata1),
        .ext_cts_i(ext1[0]), .ext_dsr_i(ext1[1]), .ext_ri_i(ext1[2]), .ext_dcd_i(ext1[3]),
        .pin_dtr_o(p1_dtr), .pin_rts_o(p1_rts), .pin_out1_o(p1_out1), .pin_out2_o(p1_out2),
        .ms_event_o(ms_ev1)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
        end
    endtask

    // status lines {dcd, ri, dsr, cts} expected from a control word, default variant
    function automatic logic [3:0] lines_of(input logic [4:0] v);
        return v[4] ? {v[3], v[2], v[0], v[1]} : 4'b0000;
    endfunction

    function automatic logic [3:0] flags_of(input logic [3:0] p, input logic [3:0] n);
        logic [3:0] c;
        c = p ^ n;
        return {c[3], p[2] & ~n[2], c[1], c[0]};
    endfunction

    task automatic wr(input logic [7:0] v);
        ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic rd();
        sts_re = 1'b1;
        @(negedge clk);
        sts_re = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset ctl", ctl_rdata, 8'h00);
        chk("R1 reset sts", sts_rdata, 8'h00);
        chk("R1 reset pins/event", {3'b0, ms_ev, p_out2, p_out1, p_rts, p_dtr}, 8'h00);

        // sweep of every pair of control words
        for (int a = 0; a < 32; a++) begin
            for (int b = 0; b < 32; b++) begin
                logic [3:0] la, lb;
                la = lines_of(a[4:0]);
                lb = lines_of(b[4:0]);
                wr({a[7:5] ^ 3'b101, a[4:0]});
                @(negedge clk);
                rd();
                chk("R9 cleared flags", {4'b0, sts_rdata[3:0]}, 8'h00);
                chk("R9 cleared event", {7'b0, ms_ev}, 8'h00);
                ext = a[3:0] ^ b[3:0];       // R5: external inputs must not matter
                wr({3'b111, b[4:0]});
                chk("R1 readback", ctl_rdata, {3'b000, b[4:0]});
                chk(b[4] ? "R3 pins idle" : "R2 pins follow",
                    {4'b0, p_out2, p_out1, p_rts, p_dtr},
                    {4'b0, b[4] ? 4'b0000 : b[3:0]});
                chk(b[4] ? "R4 loop lines" : "R5 lines zero",
                    {4'b0, sts_rdata[7:4]}, {4'b0, lb});
                chk("R6 flags not yet", {4'b0, sts_rdata[3:0]}, 8'h00);
                @(negedge clk);
                chk("R6 R7 flags", {4'b0, sts_rdata[3:0]}, {4'b0, flags_of(la, lb)});
                chk("R8 event", {7'b0, ms_ev}, {7'b0, (la != lb)});
            end
        end

        // R11 hold: set CTS and DSR flags, then idle
        wr(8'h10); @(negedge clk); rd();
        wr(8'h13); @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R11 hold", sts_rdata, 8'h33);
            chk("R11 hold event", {7'b0, ms_ev}, 8'h01);
        end
        rd();
        chk("R9 clear after hold", sts_rdata, 8'h30);

        // R10: DCD changes at the same edge as a read
        ctl_we = 1'b1; ctl_wdata = 8'h1B;
        @(negedge clk);
        ctl_we = 1'b0; sts_re = 1'b1;
        chk("R9 pre-clear read value", {4'b0, sts_rdata[3:0]}, 8'h00);
        @(negedge clk);
        sts_re = 1'b0;
        chk("R10 change kept", sts_rdata, 8'hB8);
        chk("R10 event kept", {7'b0, ms_ev}, 8'h01);

        // R12: synchronized external inputs on u1
        ext1 = 4'b1011;
        @(negedge clk);
        chk("R12 stage 1", sts_rdata1, 8'h00);
        @(negedge clk);
        chk("R12 lines", sts_rdata1, 8'hB0);
        @(negedge clk);
        chk("R12 flags", sts_rdata1, 8'hBB);
        chk("R12 event", {7'b0, ms_ev1}, 8'h01);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule